// File: doc/BRIEF.md
# Masked Port Change Interrupt

This block watches a small group of general-purpose port pins and raises a latched interrupt when any enabled pin leaves the level it held when detection was armed. Software first writes an enable mask, then arms detection with a configuration write. That write captures the present pin levels as a reference pattern. From then on, any difference on an enabled pin sets a status flag. The flag can be seen in the top bit of the mask register and, when the interrupt pin is enabled, on the interrupt output.

Detection fires once per arming. The flag stays set until the mask register is read or written. The read that clears the flag still returns it as set. Clearing the flag after an event also disarms detection, so software must arm again to take a fresh reference and watch for the next change. Pin inputs pass through a synchronizer before they are compared, so a change must last at least two clock periods to be seen reliably.

Top module: `port_change_irq`

## Requirements
- R1: After reset, detection is disarmed, the interrupt output is low, and a mask register read returns 0x00 (mask bits 6:0 clear, status bit 7 clear).
- R2: Each configuration write with data bit 7 set captures the current synchronized pin levels as the reference and arms detection, whether or not the previous configuration write had bit 7 set. Pins that stay at the captured levels raise no event.
- R3: A configuration write with bit 7 set clears the status bit and drives the interrupt output low.
- R4: A configuration write with bit 7 clear disarms detection, and later pin changes do not set the status bit.
- R5: While armed, a change on an enabled pin that lasts at least two clocks sets the status bit. The interrupt output rises at most three clock edges after the change.
- R6: Once set, the status bit stays set through further changes and after the pins return to the reference pattern.
- R7: A read or write of the mask register clears the status bit. A read in that cycle still returns bit 7 as 1, so two back-to-back mask reads after an event return bit 7 as 1 and then 0.
- R8: Clearing the status bit after an event disarms detection. Later pin changes raise nothing until the next configuration write with bit 7 set.
- R9: A change on a pin whose mask bit (bit i for pin i) is 0 does not set the status bit.
- R10: The interrupt output equals the status bit while the interrupt pin enable is high, and is low while that enable is low. The status bit is still readable in mask register bit 7.
- R11: A mask register write stores data bits 6:0, and a later mask read returns them in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portIn | input | 7 | Monitored pin levels, bit i is pin i |
| regWrEn | input | 1 | Register write strobe, one cycle per access |
| regRdEn | input | 1 | Register read strobe, one cycle per access |
| regSel | input | 1 | 0 selects the configuration register, 1 selects the mask register |
| regWrData | input | 8 | Write data; bit 7 is the arm bit of a configuration write |
| regRdData | output | 8 | Read data, valid in the cycle that regRdEn is high |
| intPinEn | input | 1 | Enables the interrupt output pin |
| intPin | output | 1 | Interrupt output |

## Verification
The hardest state to reach is a latched event whose pins have already returned to the reference pattern, so that nothing visible at the inputs explains the flag. The stimulus reaches it by arming on a known pattern and pulsing one enabled pin for exactly two clocks before restoring it. The bench then checks that the interrupt is still high. It also checks that a second arming write, issued while arming is already selected, clears the flag and takes a new reference.

// File: rtl/port_change_irq_pkg.sv
package port_change_irq_pkg;

  typedef enum logic {
    SEL_CFG  = 1'b0,
    SEL_MASK = 1'b1
  } regSel_e;

  typedef struct packed {
    logic loadSnap;
    logic loadMask;
  } dpStrobe_t;

endpackage

// File: rtl/port_change_irq_ctrl.sv
module port_change_irq_ctrl
  import port_change_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      regRdEn,
  input  logic      regSel,
  input  logic      armBit,
  input  logic      hit,
  output dpStrobe_t strobe,
  output logic      armed,
  output logic      irqFlag,
  output logic      modeReg
);

  logic cfgWr;
  logic maskAcc;

  assign cfgWr   = regWrEn && (regSel == SEL_CFG);
  assign maskAcc = (regWrEn || regRdEn) && (regSel == SEL_MASK);

  always_comb begin
    strobe          = '0;
    strobe.loadSnap = cfgWr && armBit;
    strobe.loadMask = regWrEn && (regSel == SEL_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      irqFlag <= 1'b0;
      modeReg <= 1'b0;
    end else if (cfgWr) begin
      modeReg <= armBit;
      armed   <= armBit;
      if (armBit) irqFlag <= 1'b0;
    end else if (maskAcc) begin
      if (irqFlag) begin
        irqFlag <= 1'b0;
        armed   <= 1'b0;
      end
    end else if (armed && hit) begin
      irqFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/port_change_irq_dp.sv
module port_change_irq_dp
  import port_change_irq_pkg::*;
#(
  parameter int WATCH_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WATCH_W-1:0] portIn,
  input  dpStrobe_t          strobe,
  input  logic [WATCH_W-1:0] wrData,
  input  logic               rdSel,
  input  logic               irqFlag,
  input  logic               modeReg,
  output logic               hit,
  output logic [WATCH_W:0]   rdData
);

  logic [WATCH_W-1:0] syncStage [SYNC_STAGES];
  logic [WATCH_W-1:0] livePins;
  logic [WATCH_W-1:0] snapReg;
  logic [WATCH_W-1:0] maskReg;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[0] <= '0;
          else       syncStage[0] <= portIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[s] <= '0;
          else       syncStage[s] <= syncStage[s-1];
        end
      end
    end
  endgenerate

  assign livePins = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapReg <= '0;
      maskReg <= '0;
    end else begin
      if (strobe.loadSnap) snapReg <= livePins;
      if (strobe.loadMask) maskReg <= wrData;
    end
  end

  assign hit = |((livePins ^ snapReg) & maskReg);

  always_comb begin
    if (rdSel == SEL_MASK) rdData = {irqFlag, maskReg};
    else                   rdData = {modeReg, {WATCH_W{1'b0}}};
  end

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import port_change_irq_pkg::*;
#(
  parameter int WATCH_W     = 7,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = WATCH_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WATCH_W-1:0] portIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               intPinEn,
  output logic               intPin
);

  dpStrobe_t         strobe;
  logic              hit;
  logic              armed;
  logic              irqFlag;
  logic              modeReg;
  logic [DATA_W-1:0] dpRdData;

  port_change_irq_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regSel  (regSel),
    .armBit  (regWrData[DATA_W-1]),
    .hit     (hit),
    .strobe  (strobe),
    .armed   (armed),
    .irqFlag (irqFlag),
    .modeReg (modeReg)
  );

  port_change_irq_dp #(
    .WATCH_W     (WATCH_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .portIn  (portIn),
    .strobe  (strobe),
    .wrData  (regWrData[WATCH_W-1:0]),
    .rdSel   (regSel),
    .irqFlag (irqFlag),
    .modeReg (modeReg),
    .hit     (hit),
    .rdData  (dpRdData)
  );

  assign regRdData = regRdEn ? dpRdData : '0;
  assign intPin    = irqFlag & intPinEn;

endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic regRdEn,
  input logic regSel,
  input logic armBit,
  input logic armed,
  input logic irqFlag,
  input logic intPin,
  input logic intPinEn
);

  logic cfgArm;
  logic cfgOff;
  logic maskAcc;

  assign cfgArm  = regWrEn && !regSel && armBit;
  assign cfgOff  = regWrEn && !regSel && !armBit;
  assign maskAcc = (regWrEn || regRdEn) && regSel;

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cfgArm |=> (armed && !irqFlag && !intPin)); // R3

  AST_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    cfgOff |=> !armed); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !maskAcc && !cfgArm) |=> irqFlag); // R6

  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && maskAcc) |=> (!irqFlag && !armed)); // R7

  AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(armed)); // R5

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!intPinEn && $rose(irqFlag)) |-> !intPin); // R10

endmodule

bind port_change_irq port_change_irq_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regSel   (regSel),
  .armBit   (regWrData[DATA_W-1]),
  .armed    (armed),
  .irqFlag  (irqFlag),
  .intPin   (intPin),
  .intPinEn (intPinEn)
);

// File: tb/test_port_change_irq.sv
module test_port_change_irq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] portIn = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       intPinEn = 1'b1;
  logic       intPin;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  port_change_irq i_port_change_irq (
    .clk       (clk),
    .rstN      (rstN),
    .portIn    (portIn),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .intPinEn  (intPinEn),
    .intPin    (intPin)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdMask(output logic [7:0] data);
    @(negedge clk);
    regRdEn = 1'b1; regSel = 1'b1;
    #1 data = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setPins(input logic [6:0] v);
    @(negedge clk);
    portIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 intPin", {7'd0, intPin}, 8'h00);
    rdMask(d);
    check("R1 mask read", d, 8'h00);
  endtask

  task automatic testMaskWrite();
    logic [7:0] d;
    wrReg(1'b1, 8'h7F);
    rdMask(d);
    check("R11 mask readback", d, 8'h7F);
  endtask

  task automatic testBasicEvent();
    logic [7:0] d;
    setPins(7'h00);
    wrReg(1'b0, 8'h80);
    repeat (3) @(negedge clk);
    check("R2 no event on stable pins", {7'd0, intPin}, 8'h00);
    @(negedge clk); portIn = 7'h04;
    repeat (3) @(negedge clk);
    check("R5 intPin rises", {7'd0, intPin}, 8'h01);
    rdMask(d);
    check("R7 first read", d, 8'hFF);
    rdMask(d);
    check("R7 second read", d, 8'h7F);
    check("R7 intPin cleared", {7'd0, intPin}, 8'h00);
    setPins(7'h0C);
    check("R8 disarmed after clear", {7'd0, intPin}, 8'h00);
    rdMask(d);
    check("R8 status stays low", d, 8'h7F);
  endtask

  task automatic testPulseAndRearm();
    wrReg(1'b0, 8'h80);
    repeat (3) @(negedge clk);
    check("R2 snapshot of 0x0C", {7'd0, intPin}, 8'h00);
    @(negedge clk); portIn = 7'h0D;
    repeat (2) @(negedge clk); portIn = 7'h0C;
    repeat (5) @(negedge clk);
    check("R6 sticky after return", {7'd0, intPin}, 8'h01);
    setPins(7'h00);
    check("R6 sticky through changes", {7'd0, intPin}, 8'h01);
    wrReg(1'b0, 8'h80);
    check("R3 rearm clears intPin", {7'd0, intPin}, 8'h00);
    repeat (3) @(negedge clk);
    check("R2 rearm takes new snapshot", {7'd0, intPin}, 8'h00);
  endtask

  task automatic testMaskedPin();
    logic [7:0] d;
    wrReg(1'b1, 8'h7E);
    wrReg(1'b0, 8'h80);
    setPins(7'h01);
    check("R9 masked pin ignored", {7'd0, intPin}, 8'h00);
    rdMask(d);
    check("R9 status clear", d, 8'h7E);
    setPins(7'h03);
    check("R5 unmasked pin fires", {7'd0, intPin}, 8'h01);
    rdMask(d);
    check("R7 write path read", d, 8'hFE);
  endtask

  task automatic testWriteClears();
    logic [7:0] d;
    wrReg(1'b0, 8'h80);
    setPins(7'h01);
    check("R5 event before write clear", {7'd0, intPin}, 8'h01);
    wrReg(1'b1, 8'h7E);
    check("R7 mask write clears", {7'd0, intPin}, 8'h00);
    rdMask(d);
    check("R7 status after write", d, 8'h7E);
  endtask

  task automatic testDisarm();
    logic [7:0] d;
    wrReg(1'b0, 8'h80);
    repeat (3) @(negedge clk);
    wrReg(1'b0, 8'h00);
    setPins(7'h03);
    check("R4 disarmed no intPin", {7'd0, intPin}, 8'h00);
    rdMask(d);
    check("R4 disarmed status", d, 8'h7E);
  endtask

  task automatic testPinEnable();
    logic [7:0] d;
    intPinEn = 1'b0;
    wrReg(1'b0, 8'h80);
    repeat (3) @(negedge clk);
    setPins(7'h01);
    check("R10 pin gated low", {7'd0, intPin}, 8'h00);
    intPinEn = 1'b1;
    #1 check("R10 pin follows status", {7'd0, intPin}, 8'h01);
    intPinEn = 1'b0;
    rdMask(d);
    check("R10 status readable", d, 8'hFE);
    intPinEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMaskWrite();
    testBasicEvent();
    testPulseAndRearm();
    testMaskedPin();
    testWriteClears();
    testDisarm();
    testPinEnable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule